// File: doc/BRIEF.md
# SDRAM Refresh Request Controller

This block decides when a synchronous DRAM behind an external bus controller must be refreshed. A prescaler divides the clock into ticks, and a refresh counter advances on each tick. When the counter reaches a programmable compare value it clears and raises a periodic match. With refresh enabled in ordinary mode, each match becomes an auto-refresh strobe. If an external bus cycle is in flight at that moment, the block first pulses an abort output and issues the refresh strobe on the next cycle.

With refresh enabled in self-refresh mode, the block waits until the bus is idle, issues a single entry strobe and holds a self-refresh status high. While in that state it drops every periodic match. Clearing either the enable bit or the mode bit produces a single exit strobe, and ordinary periodic operation resumes. The match also sets a sticky flag, so the counter can serve as an interval timer while refresh is off.

Software reaches the control, counter and compare registers through a small write/read port. The write takes effect on the clock edge and the read data is combinational.

Top module: `rfr_ctrl`

## Requirements
- R1: After reset the control register reads 0, the counter reads 0, the compare register reads all ones, and every strobe output and tmr_flag_o are low.
- R2: The counter (address 1) advances by one every PRESC_DIV clocks. On a tick where it equals the compare value (address 2), it clears to 0 instead.
- R3: A match sets the sticky flag at control bit 3 and drives tmr_flag_o high, whether or not refresh is enabled. Writing 0 to bit 3 clears the flag. Writing 1 leaves it unchanged and never sets it.
- R4: With the enable bit (control bit 2) at 0, no refresh, abort or self-refresh strobe is issued.
- R5: With enable 1 and mode (control bit 1) 0 and the bus idle, each match yields a single one-cycle pulse on ref_req_o, so a compare value of C gives exactly one refresh every (C+1)*PRESC_DIV clocks.
- R6: If bus_busy_i is high when a match occurs in ordinary mode, bus_abort_o pulses for exactly one cycle and ref_req_o pulses in the following cycle.
- R7: With enable 1 and mode 1, sr_enter_o pulses once only after a cycle in which bus_busy_i is low. self_refresh_o then stays high. While the bus stays busy, neither strobe appears.
- R8: While self_refresh_o is high, ref_req_o and bus_abort_o stay low regardless of matches or bus activity.
- R9: Clearing enable or mode while in self-refresh gives one sr_exit_o pulse and drops self_refresh_o. When enable is still 1 with mode 0, periodic refresh resumes.
- R10: Control bit 0 always reads 0, whatever was written to it.
- R11: The compare and counter registers read back the last value written. A counter write takes priority over a tick in the same cycle. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 control, 1 counter, 2 compare |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Read data for addr_i |
| bus_busy_i | input | 1 | External bus cycle in progress |
| bus_abort_o | output | 1 | One-cycle request to end the current bus cycle |
| ref_req_o | output | 1 | Auto-refresh command strobe |
| sr_enter_o | output | 1 | Self-refresh entry strobe |
| sr_exit_o | output | 1 | Self-refresh exit strobe |
| self_refresh_o | output | 1 | Memory is in self-refresh |
| tmr_flag_o | output | 1 | Sticky compare-match flag |

## Verification
A sequencer stuck in the abort-then-refresh state or in self-refresh shows at the ports within one match period. It appears as a missing or doubled ref_req_o, an abort with no refresh on the next cycle, or refresh strobes while self_refresh_o is high. A counter that misses its clear point is visible on the next register read, because the value climbs above the compare value. Refresh counts are compared over windows of whole periods, so a single lost or extra pulse is detected.

// File: rtl/rfr_pkg.sv
`timescale 1ns/1ps
package rfr_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_CNT  = 2'd1,
    ADDR_CMP  = 2'd2,
    ADDR_NONE = 2'd3
  } rfr_addr_e;

  localparam int unsigned CTRL_MODE_BIT = 1;
  localparam int unsigned CTRL_EN_BIT   = 2;
  localparam int unsigned CTRL_FLAG_BIT = 3;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ABREF = 2'd1,
    SQ_SELF  = 2'd2
  } sq_state_e;
endpackage

// File: rtl/rfr_prescaler.sv
`timescale 1ns/1ps
module rfr_prescaler #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_nodiv
      assign tick_o = 1'b1;
    end else begin : g_div
      logic [PW-1:0] psc_q;
      assign tick_o = (psc_q == PW'(DIV - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     psc_q <= '0;
        else if (tick_o) psc_q <= '0;
        else             psc_q <= psc_q + PW'(1);
      end
    end
  endgenerate
endmodule

// File: rtl/rfr_timer.sv
`timescale 1ns/1ps
module rfr_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o
);
  logic [CNT_W-1:0] cnt_q;

  // a software load wins over a tick
  assign match_o = tick_i && !wr_i && (cnt_q == cmp_i);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (wr_i)    cnt_q <= wdata_i;
    else if (match_o) cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + CNT_W'(1);
  end

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !tick_i) |=> $stable(cnt_q)); // R2
  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/rfr_regs.sv
`timescale 1ns/1ps
module rfr_regs
  import rfr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             match_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             cnt_wr_o,
  output logic             en_o,
  output logic             mode_o,
  output logic             flag_o
);
  logic             en_q, mode_q, flag_q;
  logic [CNT_W-1:0] cmp_q;
  logic             wr_ctrl, wr_cmp;

  assign wr_ctrl  = wr_i && (addr_i == ADDR_CTRL);
  assign wr_cmp   = wr_i && (addr_i == ADDR_CMP);
  assign cnt_wr_o = wr_i && (addr_i == ADDR_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mode_q <= 1'b0;
      cmp_q  <= '1;
    end else begin
      if (wr_ctrl) begin
        en_q   <= wdata_i[CTRL_EN_BIT];
        mode_q <= wdata_i[CTRL_MODE_BIT];
      end
      if (wr_cmp) cmp_q <= wdata_i;
    end
  end

  // set has priority; software can only clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (match_i) flag_q <= 1'b1;
    else if (wr_ctrl) flag_q <= flag_q & wdata_i[CTRL_FLAG_BIT];
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL: begin
        rdata_o[CTRL_FLAG_BIT] = flag_q;
        rdata_o[CTRL_EN_BIT]   = en_q;
        rdata_o[CTRL_MODE_BIT] = mode_q;
      end
      ADDR_CNT: rdata_o = cnt_i;
      ADDR_CMP: rdata_o = cmp_q;
      default:  rdata_o = '0;
    endcase
  end

  assign cmp_o  = cmp_q;
  assign en_o   = en_q;
  assign mode_o = mode_q;
  assign flag_o = flag_q;

  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i |=> flag_q); // R3
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !wr_ctrl) |=> flag_q); // R3
endmodule

// File: rtl/rfr_seq.sv
`timescale 1ns/1ps
module rfr_seq
  import rfr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic mode_i,
  input  logic match_i,
  input  logic bus_busy_i,
  output logic bus_abort_o,
  output logic ref_req_o,
  output logic sr_enter_o,
  output logic sr_exit_o,
  output logic self_refresh_o
);
  sq_state_e state_q;
  logic      abort_q, ref_q, ent_q, ext_q;
  logic      want_self;

  assign want_self = en_i && mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      abort_q <= 1'b0;
      ref_q   <= 1'b0;
      ent_q   <= 1'b0;
      ext_q   <= 1'b0;
    end else begin
      abort_q <= 1'b0;
      ref_q   <= 1'b0;
      ent_q   <= 1'b0;
      ext_q   <= 1'b0;
      unique case (state_q)
        SQ_IDLE: begin
          if (want_self) begin
            // self-refresh lets the running bus cycle finish
            if (!bus_busy_i) begin
              ent_q   <= 1'b1;
              state_q <= SQ_SELF;
            end
          end else if (en_i && match_i) begin
            if (bus_busy_i) begin
              abort_q <= 1'b1;
              state_q <= SQ_ABREF;
            end else begin
              ref_q <= 1'b1;
            end
          end
        end
        SQ_ABREF: begin
          ref_q   <= 1'b1;
          state_q <= SQ_IDLE;
        end
        SQ_SELF: begin
          if (!want_self) begin
            ext_q   <= 1'b1;
            state_q <= SQ_IDLE;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign bus_abort_o    = abort_q;
  assign ref_req_o      = ref_q;
  assign sr_enter_o     = ent_q;
  assign sr_exit_o      = ext_q;
  assign self_refresh_o = (state_q == SQ_SELF);

  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && state_q == SQ_IDLE) |=> (!ref_q && !abort_q && !ent_q)); // R4
  AST_ABORT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_q |=> !abort_q); // R6
  AST_REF_AFTER_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_q |=> ref_q); // R6
  AST_ENTER_BUS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_q |-> !$past(bus_busy_i)); // R7
  AST_SELF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    self_refresh_o |-> (!ref_q && !abort_q)); // R8
  AST_EXIT_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_q |-> (!self_refresh_o && $past(self_refresh_o))); // R9
endmodule

// File: rtl/rfr_ctrl.sv
`timescale 1ns/1ps
module rfr_ctrl #(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned PRESC_DIV = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  input  logic             bus_busy_i,
  output logic             bus_abort_o,
  output logic             ref_req_o,
  output logic             sr_enter_o,
  output logic             sr_exit_o,
  output logic             self_refresh_o,
  output logic             tmr_flag_o
);
  logic             tick, match, cnt_wr, en, mode;
  logic [CNT_W-1:0] cnt, cmp;

  rfr_prescaler #(.DIV(PRESC_DIV)) i_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  rfr_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .cmp_i   (cmp),
    .wr_i    (cnt_wr),
    .wdata_i (wdata_i),
    .cnt_o   (cnt),
    .match_o (match)
  );

  rfr_regs #(.CNT_W(CNT_W)) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .cnt_i    (cnt),
    .match_i  (match),
    .rdata_o  (rdata_o),
    .cmp_o    (cmp),
    .cnt_wr_o (cnt_wr),
    .en_o     (en),
    .mode_o   (mode),
    .flag_o   (tmr_flag_o)
  );

  rfr_seq i_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .en_i           (en),
    .mode_i         (mode),
    .match_i        (match),
    .bus_busy_i     (bus_busy_i),
    .bus_abort_o    (bus_abort_o),
    .ref_req_o      (ref_req_o),
    .sr_enter_o     (sr_enter_o),
    .sr_exit_o      (sr_exit_o),
    .self_refresh_o (self_refresh_o)
  );

  initial begin
    AST_WIDTH_OK: assert (CNT_W >= 4); // R10
  end
endmodule

// File: tb/test_rfr_ctrl.sv
`timescale 1ns/1ps
module test_rfr_ctrl;
  localparam int unsigned CNT_W = 8;
  localparam int unsigned DIV   = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [1:0]       addr = 2'd0;
  logic [CNT_W-1:0] wdata = '0;
  logic [CNT_W-1:0] rdata;
  logic             busy = 1'b0;
  logic             abort_s, ref_s, ent_s, ext_s, self_s, flag_s;

  int n_chk = 0, n_fail = 0;
  int c_ref = 0, c_abort = 0, c_ent = 0, c_ext = 0, c_ref_after = 0, c_abort_dbl = 0;
  logic prev_abort = 1'b0;

  always #4 clk = ~clk;

  rfr_ctrl #(.CNT_W(CNT_W), .PRESC_DIV(DIV)) i_rfr_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .bus_busy_i(busy), .bus_abort_o(abort_s), .ref_req_o(ref_s),
    .sr_enter_o(ent_s), .sr_exit_o(ext_s), .self_refresh_o(self_s), .tmr_flag_o(flag_s)
  );

  // pulse monitor, sampled 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (ref_s) c_ref++;
    if (abort_s) c_abort++;
    if (ent_s) c_ent++;
    if (ext_s) c_ext++;
    if (ref_s && prev_abort) c_ref_after++;
    if (abort_s && prev_abort) c_abort_dbl++;
    prev_abort = abort_s;
  end

  task automatic clr_mon();
    c_ref = 0; c_abort = 0; c_ent = 0; c_ext = 0; c_ref_after = 0; c_abort_dbl = 0;
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [CNT_W-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    addr = a;
    #1;
    v = int'(rdata);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {addr, write data, expected read}
  localparam logic [17:0] VEC [0:8] = '{
    {2'd2, 8'h5a, 8'h5a},
    {2'd2, 8'hff, 8'hff},
    {2'd0, 8'h01, 8'h00},
    {2'd0, 8'h03, 8'h02},
    {2'd0, 8'h08, 8'h00},
    {2'd0, 8'h04, 8'h04},
    {2'd0, 8'h00, 8'h00},
    {2'd1, 8'h10, 8'h10},
    {2'd3, 8'h77, 8'h00}
  };

  initial begin
    int v;
    int bad;
    #20 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, v); check("R1 ctrl", v, 0);
    rd(2'd1, v); check("R1 counter", v, 0);
    rd(2'd2, v); check("R1 compare", v, 255);
    check("R1 outputs", int'({abort_s, ref_s, ent_s, ext_s, self_s, flag_s}), 0);

    // register vectors: R10 reserved bit, R11 readback, R3 flag not set by 1
    foreach (VEC[i]) begin
      wr(VEC[i][17:16], VEC[i][15:8]);
      rd(VEC[i][17:16], v);
      check("R3/R10/R11 vector", v, int'(VEC[i][7:0]));
    end

    // R2 counter rate
    wr(2'd1, 8'd0);
    rd(2'd1, v); check("R2 counter loaded", v, 0);
    cyc(40);
    rd(2'd1, v); check("R2 ten ticks in 40 clocks", v, 10);

    // R2 clear at compare, R3 flag with refresh disabled
    wr(2'd2, 8'd3);
    wr(2'd1, 8'd0);
    bad = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      rd(2'd1, v);
      if (v > 3) bad++;
    end
    check("R2 counter never exceeds compare", bad, 0);
    rd(2'd0, v); check("R3 flag set while disabled", (v >> 3) & 1, 1);
    check("R3 tmr_flag_o", int'(flag_s), 1);
    wr(2'd0, 8'h08);
    check("R3 write 1 keeps flag", int'(flag_s), 1);

    // R4 disabled: no strobes
    clr_mon();
    cyc(160);
    check("R4 no refresh", c_ref, 0);
    check("R4 no abort", c_abort, 0);
    check("R4 no self entry", c_ent, 0);

    // R3 clear flag
    wr(2'd2, 8'hff);
    wr(2'd1, 8'd0);
    wr(2'd0, 8'h00);
    rd(2'd0, v); check("R3 flag cleared", (v >> 3) & 1, 0);
    check("R3 tmr_flag_o cleared", int'(flag_s), 0);

    // R5 periodic refresh, idle bus
    wr(2'd2, 8'd3);
    wr(2'd1, 8'd0);
    wr(2'd0, 8'h04);
    cyc(4);
    clr_mon();
    cyc(160);
    check("R5 refresh count", c_ref, 10);
    check("R5 no abort", c_abort, 0);

    // R6 busy bus: abort then refresh
    busy = 1'b1;
    cyc(4);
    clr_mon();
    cyc(160);
    check("R6 abort count", c_abort, 10);
    check("R6 refresh count", c_ref, 10);
    check("R6 refresh follows abort", c_ref_after, 10);
    check("R6 abort single cycle", c_abort_dbl, 0);

    // R7 self-refresh waits for bus
    wr(2'd0, 8'h06);
    cyc(4);
    clr_mon();
    cyc(20);
    check("R7 no entry while busy", c_ent, 0);
    check("R7 no refresh while waiting", c_ref, 0);
    check("R7 not in self yet", int'(self_s), 0);
    busy = 1'b0;
    @(negedge clk);
    check("R7 entry strobe", int'(ent_s), 1);
    check("R7 self status", int'(self_s), 1);
    @(negedge clk);
    check("R7 entry one cycle", int'(ent_s), 0);
    check("R7 single entry", c_ent, 1);

    // R8 requests dropped in self-refresh
    clr_mon();
    for (int k = 0; k < 160; k++) begin
      busy = k[0];
      @(negedge clk);
    end
    busy = 1'b0;
    check("R8 no refresh in self", c_ref, 0);
    check("R8 no abort in self", c_abort, 0);
    check("R8 still in self", int'(self_s), 1);

    // R9 exit via mode bit, periodic resumes
    clr_mon();
    wr(2'd0, 8'h04);
    cyc(2);
    check("R9 single exit", c_ext, 1);
    check("R9 self cleared", int'(self_s), 0);
    clr_mon();
    cyc(160);
    check("R9 refresh resumes", c_ref, 10);

    // R9 exit via enable bit
    wr(2'd0, 8'h06);
    cyc(3);
    check("R9 re-entered", int'(self_s), 1);
    clr_mon();
    wr(2'd0, 8'h00);
    cyc(40);
    check("R9 exit on disable", c_ext, 1);
    check("R9 no refresh when disabled", c_ref, 0);
    check("R9 self off", int'(self_s), 0);

    // R1 reset mid-run
    wr(2'd0, 8'h04);
    cyc(10);
    rst_n = 1'b0;
    #1;
    rd(2'd0, v); check("R1 ctrl after reset", v, 0);
    rd(2'd1, v); check("R1 counter after reset", v, 0);
    check("R1 outputs after reset", int'({abort_s, ref_s, ent_s, ext_s, self_s, flag_s}), 0);
    rst_n = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule